// File: doc/BRIEF.md
# Sequential Shift-and-Add Unsigned Multiplier

This block multiplies two unsigned N-bit operands over several clock cycles using a single N-bit adder. A one-cycle start pulse, seen while the unit is idle, captures both operands: the multiplicand goes into a holding register, the multiplier goes into a right-shifting register, and an accumulator one bit wider than the operands is cleared. The unit then handles one multiplier bit per iteration. It examines the low bit of the shifting multiplier register. A 1 adds the multiplicand into the accumulator. After that, the accumulator and multiplier registers shift right together as one 2N+1-bit chain.

The controller is a Mealy machine. Its add and shift commands are decoded from its state, the current multiplier low bit and a terminal flag from a bit counter. An iteration whose bit is 0 therefore takes one cycle, and an iteration whose bit is 1 takes two. No wait state is spent before a bit is tested. After the Nth shift the controller returns to idle and raises the done flag. The 2N-bit result is the low N bits of the accumulator joined above the multiplier register. It stays on the outputs until the next start.

Top module: `seqmul_top`

## Requirements
- R1: While reset is asserted and after it is released, done is 1 and product is 0.
- R2: A start pulse sampled while done is 1 captures mcand and mplier, and done is 0 from the following cycle.
- R3: When done returns to 1, product equals mcand × mplier as unsigned integers for every operand pair.
- R4: The adder carry is kept in the accumulator's extra bit, so operands near the maximum (such as all ones times all ones) give the full 2N-bit product.
- R5: Each shift moves the accumulator low bit into the multiplier register MSB and puts 0 into the accumulator MSB, so product = {accumulator[N-1:0], multiplier register}.
- R6: After the start pulse, done stays 0 for exactly N + (number of 1 bits in mplier) cycles. A 0 bit costs one cycle and a 1 bit costs two.
- R7: A start pulse while done is 0 is ignored. The running product and its latency do not change.
- R8: While done is 1 with start low, product holds its value even when the operand inputs change.
- R9: With N = 3, 6 × 5 gives 30.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| start | input | 1 | Begins a multiplication when sampled high in idle |
| mcand | input | N | Unsigned multiplicand |
| mplier | input | N | Unsigned multiplier |
| product | output | 2N | Unsigned product |
| done | output | 1 | High in idle; marks a valid product |

## Verification
The bench builds two copies of the block. The first uses the default N = 4, which makes all 256 operand pairs reachable, so product values and per-pair latency are checked exhaustively, including the carry-heavy all-ones case. The second uses N = 3, which makes the 6 × 5 example reachable and exercises a counter whose terminal count is not a power-of-two boundary.

// File: rtl/seqmul_pkg.sv
package seqmul_pkg;
  typedef enum logic [1:0] {
    ST_IDLE    = 2'd0,
    ST_TEST    = 2'd1,
    ST_POSTADD = 2'd2
  } seqmul_state_e;
endpackage

// File: rtl/seqmul_rstsync.sv
module seqmul_rstsync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_sync_n = sync_q[STAGES-1];
endmodule

// File: rtl/seqmul_ctrl.sv
module seqmul_ctrl
  import seqmul_pkg::*;
#(
  parameter int N = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic q_lsb,
  output logic load_o,
  output logic add_o,
  output logic shift_o,
  output logic done_o
);
  localparam int CW = (N > 1) ? $clog2(N) : 1;
  localparam logic [CW-1:0] LAST = CW'(N - 1);
  localparam int BW = $clog2(2 * N + 2) + 1;

  seqmul_state_e state_q, state_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          cnt_en;
  logic          last_shift;

  assign last_shift = (cnt_q == LAST);

  always_comb begin
    state_d = state_q;
    load_o  = 1'b0;
    add_o   = 1'b0;
    shift_o = 1'b0;
    done_o  = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        done_o = 1'b1;
        if (start) begin
          load_o  = 1'b1;
          state_d = ST_TEST;
        end
      end
      ST_TEST: begin
        if (q_lsb) begin
          add_o   = 1'b1;
          state_d = ST_POSTADD;
        end else begin
          shift_o = 1'b1;
          state_d = last_shift ? ST_IDLE : ST_TEST;
        end
      end
      ST_POSTADD: begin
        shift_o = 1'b1;
        state_d = last_shift ? ST_IDLE : ST_TEST;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_comb begin
    cnt_en = load_o | shift_o;
    cnt_d  = cnt_q;
    if (load_o)       cnt_d = '0;
    else if (shift_o) cnt_d = cnt_q + CW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= ST_IDLE;
    else        state_q <= state_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  // busy-cycle tracker for the latency bound
  logic [BW-1:0] busy_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      busy_q <= '0;
    else if (done_o) busy_q <= '0;
    else             busy_q <= busy_q + BW'(1);
  end

  AST_BUSY_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    busy_q <= BW'(2 * N)); // R6
  AST_START_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q != ST_IDLE) |-> !load_o); // R7
  AST_ONE_CMD: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({load_o, add_o, shift_o})); // R5
  AST_FINISH_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
    (!done_o && state_d == ST_IDLE) |-> (cnt_q == LAST)); // R6
endmodule

// File: rtl/seqmul_acc.sv
module seqmul_acc #(
  parameter int N = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clear,
  input  logic         add_en,
  input  logic         shift_en,
  input  logic [N-1:0] addend,
  output logic [N:0]   acc_o
);
  logic [N:0] acc_q, acc_d;
  logic       acc_en;

  always_comb begin
    acc_en = clear | add_en | shift_en;
    acc_d  = acc_q;
    if (clear)         acc_d = '0;
    else if (add_en)   acc_d = acc_q + {1'b0, addend};
    else if (shift_en) acc_d = {1'b0, acc_q[N:1]};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      acc_q <= '0;
    else if (acc_en) acc_q <= acc_d;
  end

  assign acc_o = acc_q;

  AST_NO_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    add_en |=> (acc_q >= $past(acc_q))); // R4
endmodule

// File: rtl/seqmul_shreg.sv
module seqmul_shreg #(
  parameter int W = 4,
  parameter bit SHIFTABLE = 1'b1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic         shift_en,
  input  logic         ser_in,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout
);
  logic [W-1:0] reg_q, reg_d;
  logic         reg_en;

  generate
    if (SHIFTABLE) begin : g_shift
      always_comb begin
        reg_en = load | shift_en;
        reg_d  = load ? din : {ser_in, reg_q[W-1:1]};
      end
    end else begin : g_hold
      logic unused_in;
      assign unused_in = shift_en ^ ser_in;
      always_comb begin
        reg_en = load;
        reg_d  = din;
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      reg_q <= '0;
    else if (reg_en) reg_q <= reg_d;
  end

  assign dout = reg_q;
endmodule

// File: rtl/seqmul_top.sv
module seqmul_top #(
  parameter int N = 4
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           start,
  input  logic [N-1:0]   mcand,
  input  logic [N-1:0]   mplier,
  output logic [2*N-1:0] product,
  output logic           done
);
  logic         rst_sync_n;
  logic         load, add, shift;
  logic [N:0]   acc;
  logic [N-1:0] mreg, qreg;

  seqmul_rstsync #(.STAGES(2)) i_rstsync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  seqmul_ctrl #(.N(N)) i_ctrl (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .start   (start),
    .q_lsb   (qreg[0]),
    .load_o  (load),
    .add_o   (add),
    .shift_o (shift),
    .done_o  (done)
  );

  seqmul_shreg #(.W(N), .SHIFTABLE(1'b0)) i_mreg (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .load     (load),
    .shift_en (1'b0),
    .ser_in   (1'b0),
    .din      (mcand),
    .dout     (mreg)
  );

  seqmul_shreg #(.W(N), .SHIFTABLE(1'b1)) i_qreg (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .load     (load),
    .shift_en (shift),
    .ser_in   (acc[0]),
    .din      (mplier),
    .dout     (qreg)
  );

  seqmul_acc #(.N(N)) i_acc (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .clear    (load),
    .add_en   (add),
    .shift_en (shift),
    .addend   (mreg),
    .acc_o    (acc)
  );

  assign product = {acc[N-1:0], qreg};

  AST_LOAD_INIT: assert property (@(posedge clk) disable iff (!rst_sync_n)
    load |=> (acc == '0) && (qreg == $past(mplier)) && (mreg == $past(mcand))); // R2
  AST_ADD_ONLY_ON_ONE: assert property (@(posedge clk) disable iff (!rst_sync_n)
    add |-> qreg[0]); // R3
  AST_SHIFT_CHAIN: assert property (@(posedge clk) disable iff (!rst_sync_n)
    shift |=> (acc[N] == 1'b0) && (qreg[N-1] == $past(acc[0]))); // R5
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (done && $past(done)) |-> $stable(product)); // R8
endmodule

// File: tb/test_seqmul_top.sv
module test_seqmul_top;
  localparam int N  = 4;
  localparam int N3 = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic [N-1:0] mcand = '0, mplier = '0;
  logic [2*N-1:0] product;
  logic done;

  logic start3 = 1'b0;
  logic [N3-1:0] mcand3 = '0, mplier3 = '0;
  logic [2*N3-1:0] product3;
  logic done3;

  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  seqmul_top #(.N(N)) i_seqmul_top (
    .clk(clk), .rst_n(rst_n), .start(start), .mcand(mcand),
    .mplier(mplier), .product(product), .done(done)
  );

  seqmul_top #(.N(N3)) i_seqmul_top_w3 (
    .clk(clk), .rst_n(rst_n), .start(start3), .mcand(mcand3),
    .mplier(mplier3), .product(product3), .done(done3)
  );

  // {mcand, mplier, expected product}
  localparam logic [15:0] VEC [8] = '{
    {4'd0,  4'd0,  8'd0},
    {4'd15, 4'd15, 8'd225},
    {4'd1,  4'd15, 8'd15},
    {4'd15, 4'd1,  8'd15},
    {4'd8,  4'd8,  8'd64},
    {4'd6,  4'd5,  8'd30},
    {4'd9,  4'd10, 8'd90},
    {4'd7,  4'd0,  8'd0}
  };

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // pulse start at a negedge, count cycles with done low
  task automatic run(input logic [N-1:0] a, input logic [N-1:0] b,
                     output int lat);
    mcand  = a;
    mplier = b;
    start  = 1'b1;
    @(negedge clk);
    start = 1'b0;
    lat = 0;
    while (done == 1'b0 && lat < 100) begin
      lat++;
      @(negedge clk);
    end
  endtask

  initial begin
    int lat;
    logic [2*N-1:0] held;
    @(negedge clk);
    chk("R1 reset done", done, 1);
    chk("R1 reset product", product, 0);
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk("R1 post-reset done", done, 1);
    chk("R1 post-reset product", product, 0);

    // table walk
    for (int i = 0; i < 8; i++) begin
      run(VEC[i][15:12], VEC[i][11:8], lat);
      chk("R3 table product", product, int'(VEC[i][7:0]));
      chk("R6 table latency", lat, N + $countones(VEC[i][11:8]));
    end

    // carry case and shift path
    run(4'd15, 4'd15, lat);
    chk("R4 all-ones product", product, 225);
    chk("R5 high half", product[2*N-1:N], 225 >> N);

    // start goes low after one cycle; done low next
    mcand = 4'd3; mplier = 4'd3; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk("R2 done falls after start", done, 0);
    while (done == 1'b0) @(negedge clk);
    chk("R2 captured product", product, 9);

    // exhaustive
    for (int a = 0; a < 16; a++) begin
      for (int b = 0; b < 16; b++) begin
        run(4'(a), 4'(b), lat);
        chk("R3 exhaustive product", product, a * b);
        chk("R6 exhaustive latency", lat, N + $countones(4'(b)));
      end
    end

    // start while busy is ignored
    mcand = 4'd11; mplier = 4'd13; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    lat = 1;
    @(negedge clk);
    mcand = 4'd2; mplier = 4'd0; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    lat = lat + 1;
    while (done == 1'b0 && lat < 100) begin
      lat++;
      @(negedge clk);
    end
    chk("R7 busy start product", product, 143);
    chk("R7 busy start latency", lat, N + 3);

    // idle hold with changing inputs
    held = product;
    for (int k = 0; k < 6; k++) begin
      mcand = 4'(k * 5); mplier = 4'(k * 3 + 1);
      @(negedge clk);
    end
    chk("R8 idle product held", product, int'(held));
    chk("R8 idle done held", done, 1);

    // reset mid-run
    mcand = 4'd12; mplier = 4'd12; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    @(negedge clk);
    rst_n = 1'b0;
    #1;
    chk("R1 mid-run reset done", done, 1);
    chk("R1 mid-run reset product", product, 0);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk("R1 after mid-run reset", done, 1);

    // narrow instance example
    mcand3 = 3'd6; mplier3 = 3'd5; start3 = 1'b1;
    @(negedge clk);
    start3 = 1'b0;
    lat = 0;
    while (done3 == 1'b0 && lat < 100) begin
      lat++;
      @(negedge clk);
    end
    chk("R9 six times five", product3, 30);
    chk("R9 latency", lat, N3 + 2);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule